// File: doc/BRIEF.md
# Bit-Field Deposit Unit

This execution unit serves a 32-bit processor pipeline. It recognises one major opcode and writes a bit field into a 32-bit word. The field comes either from a source register or from a small signed constant carried in the instruction. The position of the field is either fixed by the instruction or set by a 5-bit shift-amount register (SAR). That register counts its bit positions from the most significant end. The background around the field is either all zeros or the current value of the destination register.

The register read ports supply the source and the old destination values. The unit returns a result word one cycle after a valid strobe, together with the destination index, a write enable, the 3-bit condition field and a flag telling downstream nullify logic that a condition was given. The register file and the evaluation of the condition lie outside the block.

Top module: `field_deposit_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:26 equal 0x35 and either bit 11 is 1 (fixed-position forms) or bit 11 is 0 with bits 9:5 all zero (SAR form). Any other word raises `illegal`, keeps `wr_en` low and returns a zero result.
- R2: After reset every output is zero. The outputs for an instruction appear on the clock edge after the edge that samples `valid_in` high, and `res_valid` marks them. Without `valid_in`, the result holds its value, and `res_valid`, `wr_en`, `illegal` and `cond_valid` are low.
- R3: For an accepted instruction, `rd_idx` equals bits 25:21 and `cond_out` equals bits 15:13. `cond_valid` is 1 exactly when that field is nonzero.
- R4: The field length is 32 minus bits 4:0, so it runs from 1 to 32. Only the low length bits of the value are used.
- R5: When bit 10 is 0, every bit outside the field is zero.
- R6: When bit 10 is 1, every bit outside the field equals the old destination value.
- R7: In the fixed-position forms, bits 9:5 give the bit index of the field's least significant bit. When position plus length exceeds 32, the field is shortened to end at bit 31.
- R8: In the SAR form, the field's least significant bit sits at 31 minus `sar`. Field bits that would fall above bit 31 are dropped.
- R9: When bit 12 is 1, the value is a 5-bit constant in bits 20:16 with its sign in bit 16 and its magnitude bits in 20:17. The constant equals bits 20:17 minus 16 when bit 16 is set, giving -16 to 15, and it is sign-extended to 32 bits.
- R10: When bit 12 is 0, the value is `src_val`, in both the fixed-position form and the SAR form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| src_val | input | 32 | Source register value |
| dst_old | input | 32 | Current destination register value |
| sar | input | 5 | Shift-amount register |
| res_valid | output | 1 | Result strobe, one cycle after `valid_in` |
| result | output | 32 | Deposited word |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| cond_out | output | 3 | Condition field |
| cond_valid | output | 1 | Condition field nonzero |
| illegal | output | 1 | Instruction not decoded |

## Verification
The bench builds the unit with its default opcode parameter of 0x35, because the form encodings are fixed at 32 bits.

The word is small enough for full sweeps:
- every position and length pair in the fixed-position forms, with both backgrounds and both value sources;
- every SAR and length pair in the SAR form;
- all 32 constant codes.

These sweeps reach every clamp boundary and every dropped-bit case. Expected words are built bit by bit from the position, the length and the background.

// File: rtl/field_deposit_unit.sv
module field_deposit_unit #(
  parameter logic [5:0] OPCODE = 6'h35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_in,
  input  logic [31:0] insn,
  input  logic [31:0] src_val,
  input  logic [31:0] dst_old,
  input  logic [4:0]  sar,
  output logic        res_valid,
  output logic [31:0] result,
  output logic [4:0]  rd_idx,
  output logic        wr_en,
  output logic [2:0]  cond_out,
  output logic        cond_valid,
  output logic        illegal
);
  localparam int W = 32;

  logic          op_hit, var_form, fix_form, legal;
  logic [W-1:0]  konst, value, low_mask, fmask, fval, nxt;
  logic [5:0]    len;
  logic [4:0]    pos;

  assign op_hit   = insn[31:26] == OPCODE;
  assign fix_form = op_hit && insn[11];
  assign var_form = op_hit && !insn[11] && (insn[9:5] == 5'd0);
  assign legal    = fix_form || var_form;

  // sign sits in the lowest bit of the 5-bit constant
  assign konst    = {{(W-4){insn[16]}}, insn[20:17]};
  assign value    = insn[12] ? konst : src_val;

  assign len      = 6'd32 - {1'b0, insn[4:0]};
  assign low_mask = ~({W{1'b1}} << len);
  assign pos      = fix_form ? insn[9:5] : (sar ^ 5'd31);

  // left shift drops bits past the top: this is the length clamp
  assign fmask    = low_mask << pos;
  assign fval     = (value & low_mask) << pos;
  assign nxt      = insn[10] ? ((dst_old & ~fmask) | fval) : fval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      result     <= '0;
      rd_idx     <= '0;
      wr_en      <= 1'b0;
      cond_out   <= '0;
      cond_valid <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      res_valid  <= valid_in;
      wr_en      <= valid_in && legal;
      illegal    <= valid_in && !legal;
      cond_valid <= valid_in && legal && (insn[15:13] != 3'd0);
      if (valid_in) begin
        result   <= legal ? nxt : '0;
        rd_idx   <= legal ? insn[25:21] : 5'd0;
        cond_out <= legal ? insn[15:13] : 3'd0;
      end
    end
  end
endmodule

// File: rtl/field_deposit_unit_chk.sv
module field_deposit_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_in,
  input logic        res_valid,
  input logic [31:0] result,
  input logic        wr_en,
  input logic [2:0]  cond_out,
  input logic        cond_valid,
  input logic        illegal
);
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> res_valid);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!res_valid && !wr_en && $stable(result)));
  a_r1_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (res_valid && !wr_en && result == 32'd0));
  a_r3_cond_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> (wr_en && cond_out != 3'd0));
  a_r2_write_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> res_valid);
endmodule

bind field_deposit_unit field_deposit_unit_chk u_chk (.*);

// File: tb/tb_field_deposit_unit.sv
module tb_field_deposit_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] insn = '0, src_val = '0, dst_old = '0;
  logic [4:0]  sar = '0;
  logic        res_valid, wr_en, cond_valid, illegal;
  logic [31:0] result;
  logic [4:0]  rd_idx;
  logic [2:0]  cond_out;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  field_deposit_unit dut (.*);

  function automatic logic [31:0] nxt_rand(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  function automatic logic [31:0] model(logic [31:0] i, logic [31:0] s,
                                        logic [31:0] d, logic [4:0] sa);
    logic [31:0] r, v;
    int len, pos, k;
    if (i[31:26] != 6'h35 || (!i[11] && i[9:5] != 0)) return 32'd0;
    len = 32 - int'(i[4:0]);
    pos = i[11] ? int'(i[9:5]) : 31 - int'(sa);
    k   = (i[16] ? -16 : 0) + int'(i[20:17]);
    v   = i[12] ? 32'(k) : s;
    for (int b = 0; b < 32; b++)
      r[b] = (b >= pos && b < pos + len) ? v[b-pos] : (i[10] ? d[b] : 1'b0);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (insn %h sar %0d)", tag, act, exp, insn, sar);
    end
  endtask

  // drive at negedge, sample at the next negedge (one register stage)
  task automatic apply(string tag, logic [31:0] i, logic [31:0] s,
                       logic [31:0] d, logic [4:0] sa);
    logic legal;
    insn = i; src_val = s; dst_old = d; sar = sa; valid_in = 1'b1;
    @(negedge clk);
    legal = (i[31:26] == 6'h35) && (i[11] || i[9:5] == 0);
    chk(tag, result, model(i, s, d, sa));
    chk("R3 sideband",
        {27'(res_valid), wr_en, illegal, cond_valid, rd_idx, cond_out},
        {27'(1), legal, !legal, legal && i[15:13] != 0,
         legal ? i[25:21] : 5'd0, legal ? i[15:13] : 3'd0});
  endtask

  function automatic logic [31:0] fix_insn(logic [4:0] rd, logic [4:0] r,
      logic [2:0] c, logic k, logic nz, logic [4:0] cp, logic [4:0] cl);
    return {6'h35, rd, r, c, k, 1'b1, nz, cp, cl};
  endfunction

  function automatic logic [31:0] var_insn(logic [4:0] rd, logic [4:0] r,
      logic [2:0] c, logic k, logic nz, logic [4:0] cl);
    return {6'h35, rd, r, c, k, 1'b0, nz, 5'd0, cl};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset", {res_valid, wr_en, illegal, cond_valid, result},
        {4'b0, 32'd0});
    chk("R2 reset idx", {24'd0, rd_idx, cond_out}, 32'd0);
    rst_n = 1'b1;

    // R4: length sweep with all-ones source at position 0, zero background
    for (int cl = 0; cl < 32; cl++)
      apply("R4 length", fix_insn(5'd1, 5'd0, 3'd0, 1'b0, 1'b0, 5'd0, 5'(cl)),
            32'hFFFF_FFFF, 32'hA5A5_A5A5, 5'd0);

    // R9: every constant code, full-length field, zero background
    for (int code = 0; code < 32; code++)
      apply("R9 constant", fix_insn(5'd2, 5'(code), 3'd0, 1'b1, 1'b0, 5'd0, 5'd0),
            32'h0, 32'hFFFF_FFFF, 5'd0);

    // R5 R6 R7 R9 R10: fixed-position sweep
    for (int cp = 0; cp < 32; cp++)
      for (int cl = 0; cl < 32; cl++)
        for (int m = 0; m < 4; m++) begin
          string tag;
          logic [31:0] s, d, i;
          rng = nxt_rand(rng); s = rng;
          rng = nxt_rand(rng); d = rng;
          i = fix_insn(rng[4:0], rng[9:5], rng[12:10], m[1], m[0], 5'(cp), 5'(cl));
          tag = $sformatf("%s %s%s", m[1] ? "R9" : "R10", m[0] ? "R6" : "R5",
                          (cp + 32 - cl > 32) ? " R7 clamp" : " R7");
          apply(tag, i, s, d, 5'd0);
        end

    // R8 with R5 R6 R9 R10: SAR-positioned sweep
    for (int sa = 0; sa < 32; sa++)
      for (int cl = 0; cl < 32; cl++)
        for (int m = 0; m < 4; m++) begin
          logic [31:0] s, d, i;
          rng = nxt_rand(rng); s = rng;
          rng = nxt_rand(rng); d = rng;
          i = var_insn(rng[4:0], rng[9:5], rng[12:10], m[1], m[0], 5'(cl));
          apply(m[1] ? "R8 R9 sar" : "R8 R10 sar", i, s, d, 5'(sa));
        end

    // R1: undecoded words
    for (int cp = 1; cp < 32; cp++)
      apply("R1 illegal sar form", {6'h35, 5'd3, 5'd4, 3'd1, 1'b0, 1'b0, 1'b1, 5'(cp), 5'd0},
            32'hFFFF_FFFF, 32'h1, 5'd7);
    apply("R1 wrong opcode", {6'h34, 26'h3FF_FFFF}, 32'hFFFF_FFFF, 32'h1, 5'd0);
    apply("R1 wrong opcode", {6'h00, 26'h000_0800}, 32'h1, 32'h1, 5'd0);

    // R2: idle cycles keep the result and lower the strobes
    apply("R6 before idle", fix_insn(5'd9, 5'd0, 3'd5, 1'b0, 1'b1, 5'd4, 5'd24),
          32'h0000_00AB, 32'hFFFF_0000, 5'd0);
    begin
      logic [31:0] keep;
      keep = result;
      valid_in = 1'b0; insn = 32'hFFFF_FFFF; src_val = '1; dst_old = '0;
      repeat (3) begin
        @(negedge clk);
        chk("R2 idle hold", result, keep);
        chk("R2 idle strobes", {28'd0, res_valid, wr_en, illegal, cond_valid}, 32'd0);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule